// File: doc/BRIEF.md
# Synchronous Single-Port Block Memory With Selectable Write View

This block models one port of an on-chip block memory: a word-addressed storage array with a single registered output. Every access happens on the rising clock edge and only while the port enable is high. A write stores the input word at the addressed location. A parameter decides what the output register shows in the cycle of a write. It can show the word just written, the word that the location held before the write, or the value it already had.

The output register also has a synchronous clear input. When the port is enabled, that input loads a parameter-defined constant into the output register, and the write path keeps working in the same cycle. The storage starts from parameter contents. These are packed into 256-bit vectors, and each vector holds as many consecutive words as fit in it, with the lowest address in the least significant bits. An asynchronous active-low reset returns the array to those contents and the output register to the clear constant. Its release is synchronised to the clock.

Top module: `bram_port`

## Requirements
- R1: While `rst_n` is low, `rdata` equals `RST_VAL` and the array returns to its initial contents. The release of `rst_n` takes effect after two rising clock edges.
- R2: With the default 16-bit word, initial word w sits at bits [(w mod 16)*16 +: 16] of init vector w/16. Word 0 is therefore in the least significant 16 bits of vector 0, and word 15 is in its most significant 16 bits.
- R3: When `port_en`=1, `wr_en`=0 and `sreset`=0, `rdata` shows the word at `addr` one clock after the edge.
- R4: When `port_en`=1 and `wr_en`=1, the word `wdata` is stored at `addr` on the rising edge.
- R5: With `MODE`=WM_WRITE_FIRST (the default), a write cycle without `sreset` puts `wdata` on `rdata`.
- R6: With `MODE`=WM_READ_FIRST, a write cycle without `sreset` puts on `rdata` the word the location held before the write.
- R7: With `MODE`=WM_NO_CHANGE, a write cycle without `sreset` leaves `rdata` unchanged.
- R8: When `port_en`=1 and `sreset`=1, `rdata` becomes `RST_VAL` after the edge, whatever `wr_en` is.
- R9: If `sreset` and `wr_en` are both high with `port_en`=1, the write to the array still takes place.
- R10: When `port_en`=0, neither `rdata` nor the array changes, whatever `wr_en`, `sreset`, `addr` and `wdata` are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| port_en | input | 1 | Port enable; gates every read, write and clear |
| wr_en | input | 1 | Write enable |
| sreset | input | 1 | Synchronous clear of the output register to `RST_VAL` |
| addr | input | ADDR_W | Word address |
| wdata | input | WORD_W | Write data |
| rdata | output | WORD_W | Registered read data |

## Verification
On every cycle, the assertions check four things: the read update of the output, the write view chosen by the mode, the priority of the synchronous clear, and the freeze of both output and array while the port is disabled. They also check that each enabled write lands in the array, including writes made alongside a clear. Only the bench scenarios can show the packed initial layout and the reload of contents by the asynchronous reset. To do so, they read back every address after reset. The bench also runs one stimulus sequence into three copies of the block, one per mode, so that the three write views can be compared in the same cycles.

// File: rtl/bram_pkg.sv
package bram_pkg;

  // Width of one packed initialisation vector.
  localparam int INIT_VEC_W = 256;

  // What the output register shows during a write cycle.
  typedef enum logic [1:0] {
    WM_WRITE_FIRST = 2'd0,
    WM_READ_FIRST  = 2'd1,
    WM_NO_CHANGE   = 2'd2
  } wr_mode_e;

endpackage

// File: rtl/bram_rst_sync.sv
module bram_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sn = sync_q[STAGES-1];

endmodule

// File: rtl/bram_store.sv
module bram_store
  import bram_pkg::*;
#(
  parameter int DEPTH     = 256,
  parameter int WORD_W    = 16,
  parameter int ADDR_W    = $clog2(DEPTH),
  parameter int INIT_VECS = (DEPTH * WORD_W + INIT_VEC_W - 1) / INIT_VEC_W,
  parameter logic [INIT_VECS-1:0][INIT_VEC_W-1:0] INIT_VEC = '0
) (
  input  logic              clk,
  input  logic              rst_sn,
  input  logic              port_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rd_word
);

  localparam int FLAT_W = INIT_VECS * INIT_VEC_W;
  localparam logic [FLAT_W-1:0] INIT_FLAT = INIT_VEC;

  logic [WORD_W-1:0] mem_q [DEPTH];
  logic              wr_go;

  // Write strobe: enable gates everything, clear does not block a write.
  always_comb begin
    wr_go = port_en & wr_en;
  end

  // Array: reset reloads the packed initial contents, word w at w*WORD_W.
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      for (int w = 0; w < DEPTH; w++) begin
        mem_q[w] <= INIT_FLAT[w*WORD_W +: WORD_W];
      end
    end else if (wr_go) begin
      mem_q[addr] <= wdata;
    end
  end

  // Pre-write contents of the addressed word, consumed by the output stage.
  assign rd_word = mem_q[addr];

  // R4 / R9: an enabled write lands, whether or not a clear rides along.
  assert_write_lands_R4: assert property (@(posedge clk) disable iff (!rst_sn)
    (port_en && wr_en) |=> mem_q[$past(addr)] == $past(wdata));

  // R10: a disabled port leaves the addressed word untouched.
  assert_idle_keeps_word_R10: assert property (@(posedge clk) disable iff (!rst_sn)
    !port_en |=> mem_q[$past(addr)] == $past(rd_word));

endmodule

// File: rtl/bram_out_stage.sv
module bram_out_stage
  import bram_pkg::*;
#(
  parameter int                WORD_W  = 16,
  parameter wr_mode_e          MODE    = WM_WRITE_FIRST,
  parameter logic [WORD_W-1:0] RST_VAL = '0
) (
  input  logic              clk,
  input  logic              rst_sn,
  input  logic              port_en,
  input  logic              wr_en,
  input  logic              sreset,
  input  logic [WORD_W-1:0] wdata,
  input  logic [WORD_W-1:0] rd_word,
  output logic [WORD_W-1:0] rdata
);

  logic [WORD_W-1:0] dout_q;
  logic [WORD_W-1:0] dout_d;
  logic [WORD_W-1:0] wr_view;

  // The mode parameter picks the word shown during a write.
  generate
    if (MODE == WM_READ_FIRST) begin : g_read_first
      assign wr_view = rd_word;
    end else if (MODE == WM_NO_CHANGE) begin : g_no_change
      assign wr_view = dout_q;
    end else begin : g_write_first
      assign wr_view = wdata;
    end
  endgenerate

  always_comb begin
    dout_d = dout_q;
    if (port_en) begin
      if (sreset) begin
        dout_d = RST_VAL;
      end else if (wr_en) begin
        dout_d = wr_view;
      end else begin
        dout_d = rd_word;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      dout_q <= RST_VAL;
    end else begin
      dout_q <= dout_d;
    end
  end

  assign rdata = dout_q;

  // R3: plain read shows the addressed word one edge later.
  assert_read_update_R3: assert property (@(posedge clk) disable iff (!rst_sn)
    (port_en && !wr_en && !sreset) |=> rdata == $past(rd_word));

  // R8: clear wins over both the read and the write view.
  assert_clear_value_R8: assert property (@(posedge clk) disable iff (!rst_sn)
    (port_en && sreset) |=> rdata == RST_VAL);

  // R10: a disabled port freezes the output, clear included.
  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_sn)
    !port_en |=> $stable(rdata));

  generate
    if (MODE == WM_READ_FIRST) begin : g_chk_rf
      // R6: output carries the pre-write contents.
      assert_old_word_R6: assert property (@(posedge clk) disable iff (!rst_sn)
        (port_en && wr_en && !sreset) |=> rdata == $past(rd_word));
    end else if (MODE == WM_NO_CHANGE) begin : g_chk_nc
      // R7: output holds across the write.
      assert_hold_on_write_R7: assert property (@(posedge clk) disable iff (!rst_sn)
        (port_en && wr_en && !sreset) |=> $stable(rdata));
    end else begin : g_chk_wf
      // R5: output carries the data being written.
      assert_new_word_R5: assert property (@(posedge clk) disable iff (!rst_sn)
        (port_en && wr_en && !sreset) |=> rdata == $past(wdata));
    end
  endgenerate

endmodule

// File: rtl/bram_port.sv
module bram_port
  import bram_pkg::*;
#(
  parameter int                DEPTH     = 256,
  parameter int                WORD_W    = 16,
  parameter wr_mode_e          MODE      = WM_WRITE_FIRST,
  parameter logic [WORD_W-1:0] RST_VAL   = '0,
  parameter int                ADDR_W    = $clog2(DEPTH),
  parameter int                INIT_VECS = (DEPTH * WORD_W + INIT_VEC_W - 1) / INIT_VEC_W,
  parameter logic [INIT_VECS-1:0][INIT_VEC_W-1:0] INIT_VEC = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              port_en,
  input  logic              wr_en,
  input  logic              sreset,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata
);

  logic              rst_sn;
  logic [WORD_W-1:0] rd_word;

  bram_rst_sync #(
    .STAGES (2)
  ) u_rst_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  bram_store #(
    .DEPTH     (DEPTH),
    .WORD_W    (WORD_W),
    .ADDR_W    (ADDR_W),
    .INIT_VECS (INIT_VECS),
    .INIT_VEC  (INIT_VEC)
  ) u_store (
    .clk     (clk),
    .rst_sn  (rst_sn),
    .port_en (port_en),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .rd_word (rd_word)
  );

  bram_out_stage #(
    .WORD_W  (WORD_W),
    .MODE    (MODE),
    .RST_VAL (RST_VAL)
  ) u_out (
    .clk     (clk),
    .rst_sn  (rst_sn),
    .port_en (port_en),
    .wr_en   (wr_en),
    .sreset  (sreset),
    .wdata   (wdata),
    .rd_word (rd_word),
    .rdata   (rdata)
  );

endmodule

// File: tb/test_bram_port.sv
`timescale 1ns/1ps
module test_bram_port;
  import bram_pkg::*;

  localparam logic [15:0] CLR = 16'hBEEF;

  // Initial word w = {~w[7:0], w[7:0]}, packed per R2.
  function automatic logic [15:0][255:0] mk_init();
    logic [15:0][255:0] v;
    v = '0;
    for (int w = 0; w < 256; w++) begin
      logic [7:0] b;
      b = 8'(w);
      v[w/16][(w%16)*16 +: 16] = {~b, b};
    end
    return v;
  endfunction

  localparam logic [15:0][255:0] INIT = mk_init();

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        port_en = 1'b0;
  logic        wr_en = 1'b0;
  logic        sreset = 1'b0;
  logic [7:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] q_wf, q_rf, q_nc;
  int          total = 0;
  int          bad = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  bram_port #(.MODE(WM_WRITE_FIRST), .RST_VAL(CLR), .INIT_VEC(INIT)) i_bram_port (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .wr_en(wr_en), .sreset(sreset),
    .addr(addr), .wdata(wdata), .rdata(q_wf));

  bram_port #(.MODE(WM_READ_FIRST), .RST_VAL(CLR), .INIT_VEC(INIT)) i_bram_port_rf (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .wr_en(wr_en), .sreset(sreset),
    .addr(addr), .wdata(wdata), .rdata(q_rf));

  bram_port #(.MODE(WM_NO_CHANGE), .RST_VAL(CLR), .INIT_VEC(INIT)) i_bram_port_nc (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .wr_en(wr_en), .sreset(sreset),
    .addr(addr), .wdata(wdata), .rdata(q_nc));

  typedef struct packed {
    logic        en;
    logic        we;
    logic        clr;
    logic [7:0]  a;
    logic [15:0] d;
    logic [15:0] x_wf;
    logic [15:0] x_rf;
    logic [15:0] x_nc;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 1'b0, 8'h03, 16'h0000, 16'hFC03, 16'hFC03, 16'hFC03, 4'd3},  // R3 R2
    '{1'b1, 1'b1, 1'b0, 8'h03, 16'h1234, 16'h1234, 16'hFC03, 16'hFC03, 4'd5},  // R5 R6 R7
    '{1'b1, 1'b0, 1'b0, 8'h03, 16'h0000, 16'h1234, 16'h1234, 16'h1234, 4'd4},  // R4
    '{1'b0, 1'b1, 1'b0, 8'h03, 16'h5555, 16'h1234, 16'h1234, 16'h1234, 4'd10}, // R10
    '{1'b1, 1'b0, 1'b0, 8'h03, 16'h0000, 16'h1234, 16'h1234, 16'h1234, 4'd10}, // R10 no write
    '{1'b1, 1'b0, 1'b1, 8'h03, 16'h0000, CLR,      CLR,      CLR,      4'd8},  // R8
    '{1'b1, 1'b1, 1'b1, 8'h10, 16'hABCD, CLR,      CLR,      CLR,      4'd8},  // R8 over write
    '{1'b1, 1'b0, 1'b0, 8'h10, 16'h0000, 16'hABCD, 16'hABCD, 16'hABCD, 4'd9},  // R9
    '{1'b0, 1'b0, 1'b1, 8'h10, 16'h0000, 16'hABCD, 16'hABCD, 16'hABCD, 4'd10}, // R10 clear idle
    '{1'b1, 1'b0, 1'b0, 8'hFF, 16'h0000, 16'h00FF, 16'h00FF, 16'h00FF, 4'd2},  // R2 last word
    '{1'b1, 1'b1, 1'b0, 8'h00, 16'h0F0F, 16'h0F0F, 16'hFF00, 16'h00FF, 4'd6},  // R5 R6 R7
    '{1'b1, 1'b1, 1'b0, 8'h00, 16'hF0F0, 16'hF0F0, 16'h0F0F, 16'h00FF, 4'd7},  // back-to-back write
    '{1'b1, 1'b0, 1'b0, 8'h00, 16'h0000, 16'hF0F0, 16'hF0F0, 16'hF0F0, 4'd4},  // R4
    '{1'b1, 1'b0, 1'b0, 8'h0F, 16'h0000, 16'hF00F, 16'hF00F, 16'hF00F, 4'd2},  // R2 top of vector 0
    '{1'b1, 1'b0, 1'b0, 8'h10, 16'h0000, 16'hABCD, 16'hABCD, 16'hABCD, 4'd9},  // R9
    '{1'b1, 1'b0, 1'b0, 8'h1F, 16'h0000, 16'hE01F, 16'hE01F, 16'hE01F, 4'd2}   // R2 vector 1
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag, input logic [15:0] exp);
    check({tag, " wf"}, q_wf, exp);
    check({tag, " rf"}, q_rf, exp);
    check({tag, " nc"}, q_nc, exp);
  endtask

  task automatic idle(input int n);
    port_en = 1'b0; wr_en = 1'b0; sreset = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check_all("R1 reset value", CLR);
    rst_n = 1'b1;
    idle(3);
    check_all("R1 after release", CLR);

    // Table walk: drive at a falling edge, check at the next one.
    for (int i = 0; i < NV; i++) begin
      port_en = VECS[i].en;
      wr_en   = VECS[i].we;
      sreset  = VECS[i].clr;
      addr    = VECS[i].a;
      wdata   = VECS[i].d;
      @(negedge clk);
      check($sformatf("R%0d row%0d wf", VECS[i].req, i), q_wf, VECS[i].x_wf);
      check($sformatf("R%0d row%0d rf", VECS[i].req, i), q_rf, VECS[i].x_rf);
      check($sformatf("R%0d row%0d nc", VECS[i].req, i), q_nc, VECS[i].x_nc);
    end

    // R1: asynchronous reset mid-run clears the output without a clock edge.
    idle(1);
    #1 rst_n = 1'b0;
    #0.5;
    check_all("R1 async clear", CLR);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    // R1: release lags two edges; an enabled read right away must not act.
    port_en = 1'b1; addr = 8'h03;
    @(negedge clk);
    check_all("R1 release sync", CLR);
    idle(2);

    // R1 R2 R3: every word is back to its packed initial value.
    for (int a = 0; a < 256; a++) begin
      logic [7:0] b;
      b = 8'(a);
      port_en = 1'b1; wr_en = 1'b0; sreset = 1'b0; addr = b;
      @(negedge clk);
      check($sformatf("R2 init word %0d", a), q_wf, {~b, b});
      check($sformatf("R1 reload rf %0d", a), q_rf, {~b, b});
      check($sformatf("R3 read nc %0d", a), q_nc, {~b, b});
    end

    // R7 R6 R5: write after clear, boundary address 0xFF.
    port_en = 1'b1; wr_en = 1'b0; sreset = 1'b1; addr = 8'hFF;
    @(negedge clk);
    wr_en = 1'b1; sreset = 1'b0; wdata = 16'h7E57;
    @(negedge clk);
    check("R5 wf at top", q_wf, 16'h7E57);
    check("R6 rf at top", q_rf, 16'h00FF);
    check("R7 nc at top", q_nc, CLR);
    wr_en = 1'b0;
    @(negedge clk);
    check_all("R4 top stored", 16'h7E57);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule